// File: doc/BRIEF.md
# Memory-Mapped Switch and LED Bus Slave

This block is a small peripheral on a synchronous 32-bit processor bus that marks each access with an active-low transfer-start strobe. It offers two word-wide locations. One is a read-only input port that returns the current state of eight DIP switches and four auxiliary switches (toggles and pushbuttons). The other is a write-only output register that holds an 8-bit value for a seven-segment display and an 8-bit bar-graph pattern.

To keep the decoder small, the chip select compares only six address lines and uses one further line to pick the register. Every other address bit is ignored, so each register also answers at many alias (shadow) addresses. Every decoded access completes with zero wait states. The block returns an active-low acknowledge that the processor samples at exactly one rising edge. The acknowledge and the read data change on falling clock edges, which gives about half a cycle of setup and hold around the rising edge where they are sampled. A data-output enable tells the pad logic when read data may be placed on the shared bus.

Top module: `swled_bus_slave`

## Requirements
- R1: The block responds only when transfer start is low and `addr_i[25:20]` equals `6'b101001`, which matches byte address 0x0290_0000. Any other address gives no acknowledge, no output enable and no register load.
- R2: Address bits outside `addr_i[25:20]` and `addr_i[2]` are ignored. Any values of those bits reach the same register as the base address.
- R3: For a decoded transfer whose start is sampled at rising edge k, `ack_n_o` goes low at the falling edge after edge k and returns high at the falling edge after edge k+1. It is therefore low at rising edge k+1 only.
- R4: Read data from the input port puts the DIP switches in `rdata_o[7:0]` (bus bits 24–31 in big-endian numbering) and the auxiliary switches in `rdata_o[11:8]` (bus bits 20–23). All other bits are zero.
- R5: `rdata_oe_o` is high only during the acknowledge window of a read of the input port. Whenever it is low, `rdata_o` is all zeros.
- R6: A write to the output register loads `seg_val_o` from `wdata_i[7:0]` and `bar_o` from `wdata_i[15:8]` (1 = lit) at rising edge k+1. Bits `wdata_i[31:16]` are ignored.
- R7: A read of the output-register address is acknowledged, but it does not assert `rdata_oe_o`, returns zero data and leaves the outputs unchanged.
- R8: A write to the input-port address is acknowledged and leaves `seg_val_o` and `bar_o` unchanged.
- R9: While `rst_n_i` is low, `ack_n_o` is high, `rdata_oe_o` is low, and `rdata_o`, `seg_val_o` and `bar_o` are zero.
- R10: `addr_i[2]` (byte weight 4) selects the register: 0 selects the input port and 1 selects the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_n_i | input | 1 | Synchronous active-low reset |
| xfer_start_n_i | input | 1 | Transfer start, active low, one cycle per access |
| addr_i | input | 32 | Byte address; vector bit n has weight 2^n |
| rd_wr_i | input | 1 | 1 = read, 0 = write |
| wdata_i | input | 32 | Write data from the processor |
| rdata_o | output | 32 | Read data toward the pads, zero when not enabled |
| rdata_oe_o | output | 1 | Enable for the pad drivers of the read data |
| ack_n_o | output | 1 | Transfer acknowledge, active low (open-drain pad outside) |
| sw_dip_i | input | 8 | DIP switch states |
| sw_aux_i | input | 4 | Toggle and pushbutton switch states |
| seg_val_o | output | 8 | Value for the seven-segment display |
| bar_o | output | 8 | Bar-graph pattern |

## Verification
In the acknowledge cycle of a write, the acknowledge output and the output-register load happen at the same rising edge. On a read, the output enable and the acknowledge share one half-cycle window. The bench starts writes at the base address and at shadow addresses, and reads at both register addresses. At the rising edge that follows each start it compares the acknowledge, the enable, the read data and the displayed values against a model kept in the bench. It also checks that the acknowledge is high at the start edge and again after the next falling edge, which shows that exactly one sampling edge sees it low.

// File: rtl/swled_pkg.sv
// Shared types for the switch/LED bus slave.
// Assumes a single clock domain and a decoded request of three flags.
package swled_pkg;

    // Request captured at the rising edge where transfer start is seen.
    typedef struct packed {
        logic hit;      // address matched the chip-select field
        logic is_read;  // 1 = read access
        logic sel_out;  // 1 = output register, 0 = input port
    } req_t;

endpackage

// File: rtl/swled_addr_decode.sv
// Partial address decoder: compares one contiguous chip-select field and
// takes one line as the register select. Every other address bit is ignored
// on purpose, so each register answers at its shadow addresses too.
module swled_addr_decode #(
    parameter int          ADDR_W   = 32,
    parameter int          CS_HI    = 25,
    parameter int          CS_LO    = 20,
    parameter logic [31:0] CS_MATCH = 32'h29,
    parameter int          SEL_BIT  = 2
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              start_n_i,
    input  logic              rd_i,
    output swled_pkg::req_t   req_o
);
    localparam int CS_W = CS_HI - CS_LO + 1;

    logic [CS_W-1:0] cs_field;
    logic            unused_addr;

    assign cs_field    = addr_i[CS_HI:CS_LO];
    assign unused_addr = ^addr_i;

    // Form the request flags from the strobe and the decoded address.
    always_comb begin
        req_o.hit     = !start_n_i && (cs_field == CS_MATCH[CS_W-1:0]);
        req_o.is_read = rd_i;
        req_o.sel_out = addr_i[SEL_BIT];
    end
endmodule

// File: rtl/swled_req_stage.sv
// Holds the decoded request for one cycle after the transfer-start edge.
// Assumes the processor starts no new access before the acknowledge.
module swled_req_stage (
    input  logic            clk_i,
    input  logic            rst_n_i,
    input  swled_pkg::req_t req_i,
    output swled_pkg::req_t pend_o
);
    // Capture the request at each rising edge; clear it on reset.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            pend_o <= '0;
        end else begin
            pend_o <= req_i;
        end
    end
endmodule

// File: rtl/swled_fall_drive.sv
// Drives acknowledge, read enable and read data from falling edges, so that
// each holds from one falling edge to the next around the sampling edge.
// Assumes DIP_W + AUX_W <= DATA_W.
module swled_fall_drive #(
    parameter int DATA_W = 32,
    parameter int DIP_W  = 8,
    parameter int AUX_W  = 4
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  swled_pkg::req_t   pend_i,
    input  logic [DIP_W-1:0]  dip_i,
    input  logic [AUX_W-1:0]  aux_i,
    output logic              ack_n_o,
    output logic              oe_o,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int AUX_LO = DIP_W;
    localparam int AUX_HI = DIP_W + AUX_W - 1;

    logic              rd_go;
    logic [DATA_W-1:0] port_word;

    // Only a decoded read of the input port places data on the bus.
    assign rd_go = pend_i.hit && pend_i.is_read && !pend_i.sel_out;

    // Pack the switch states into the read word; unused bits read zero.
    always_comb begin
        port_word                 = '0;
        port_word[DIP_W-1:0]      = dip_i;
        port_word[AUX_HI:AUX_LO]  = aux_i;
    end

    // Launch or withdraw acknowledge and read data at each falling edge.
    always_ff @(negedge clk_i) begin
        if (!rst_n_i) begin
            ack_n_o <= 1'b1;
            oe_o    <= 1'b0;
            rdata_o <= '0;
        end else begin
            ack_n_o <= !pend_i.hit;
            oe_o    <= rd_go;
            rdata_o <= rd_go ? port_word : '0;
        end
    end
endmodule

// File: rtl/swled_out_reg.sv
// Output register for the seven-segment value and the bar-graph pattern.
// Loads at the rising edge that coincides with the acknowledge of a write.
// Data bits above SEG_W + BAR_W are ignored.
module swled_out_reg #(
    parameter int DATA_W = 32,
    parameter int SEG_W  = 8,
    parameter int BAR_W  = 8
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  swled_pkg::req_t   pend_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [SEG_W-1:0]  seg_o,
    output logic [BAR_W-1:0]  bar_o
);
    localparam int BAR_LO = SEG_W;
    localparam int BAR_HI = SEG_W + BAR_W - 1;

    logic load;
    logic unused_wdata;

    assign load         = pend_i.hit && !pend_i.is_read && pend_i.sel_out;
    assign unused_wdata = ^wdata_i;

    // Take new display values on a decoded write of the output register.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            seg_o <= '0;
            bar_o <= '0;
        end else if (load) begin
            seg_o <= wdata_i[SEG_W-1:0];
            bar_o <= wdata_i[BAR_HI:BAR_LO];
        end
    end
endmodule

// File: rtl/swled_bus_slave.sv
// Top of the switch/LED bus slave: a partial decoder, a one-cycle request
// stage, falling-edge bus drivers and the output register.
// Assumes zero-wait word accesses and no new start before the acknowledge.
module swled_bus_slave #(
    parameter int          ADDR_W   = 32,
    parameter int          DATA_W   = 32,
    parameter int          CS_HI    = 25,
    parameter int          CS_LO    = 20,
    parameter logic [31:0] CS_MATCH = 32'h29,
    parameter int          SEL_BIT  = 2,
    parameter int          DIP_W    = 8,
    parameter int          AUX_W    = 4,
    parameter int          SEG_W    = 8,
    parameter int          BAR_W    = 8
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              xfer_start_n_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rdata_oe_o,
    output logic              ack_n_o,
    input  logic [DIP_W-1:0]  sw_dip_i,
    input  logic [AUX_W-1:0]  sw_aux_i,
    output logic [SEG_W-1:0]  seg_val_o,
    output logic [BAR_W-1:0]  bar_o
);
    swled_pkg::req_t req;
    swled_pkg::req_t pend;

    // Reject field layouts that do not fit the data word.
    generate
        if ((SEG_W + BAR_W > DATA_W) || (DIP_W + AUX_W > DATA_W)) begin : g_bad_layout
            $error("field widths exceed the data word");
        end
    endgenerate

    swled_addr_decode #(
        .ADDR_W  (ADDR_W),
        .CS_HI   (CS_HI),
        .CS_LO   (CS_LO),
        .CS_MATCH(CS_MATCH),
        .SEL_BIT (SEL_BIT)
    ) i_decode (
        .addr_i   (addr_i),
        .start_n_i(xfer_start_n_i),
        .rd_i     (rd_wr_i),
        .req_o    (req)
    );

    swled_req_stage i_stage (
        .clk_i  (clk_i),
        .rst_n_i(rst_n_i),
        .req_i  (req),
        .pend_o (pend)
    );

    swled_fall_drive #(
        .DATA_W(DATA_W),
        .DIP_W (DIP_W),
        .AUX_W (AUX_W)
    ) i_drive (
        .clk_i  (clk_i),
        .rst_n_i(rst_n_i),
        .pend_i (pend),
        .dip_i  (sw_dip_i),
        .aux_i  (sw_aux_i),
        .ack_n_o(ack_n_o),
        .oe_o   (rdata_oe_o),
        .rdata_o(rdata_o)
    );

    swled_out_reg #(
        .DATA_W(DATA_W),
        .SEG_W (SEG_W),
        .BAR_W (BAR_W)
    ) i_out (
        .clk_i  (clk_i),
        .rst_n_i(rst_n_i),
        .pend_i (pend),
        .wdata_i(wdata_i),
        .seg_o  (seg_val_o),
        .bar_o  (bar_o)
    );
endmodule

// File: rtl/swled_bus_slave_chk.sv
// Protocol checker for the switch/LED bus slave, bound to the top module.
// Assumes the processor starts no new access before the acknowledge.
module swled_bus_slave_chk #(
    parameter int          ADDR_W   = 32,
    parameter int          DATA_W   = 32,
    parameter int          CS_HI    = 25,
    parameter int          CS_LO    = 20,
    parameter logic [31:0] CS_MATCH = 32'h29,
    parameter int          SEL_BIT  = 2,
    parameter int          DIP_W    = 8,
    parameter int          AUX_W    = 4,
    parameter int          SEG_W    = 8,
    parameter int          BAR_W    = 8
) (
    input logic              clk_i,
    input logic              rst_n_i,
    input logic              xfer_start_n_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              rd_wr_i,
    input logic [DATA_W-1:0] wdata_i,
    input logic [DATA_W-1:0] rdata_o,
    input logic              rdata_oe_o,
    input logic              ack_n_o,
    input logic [DIP_W-1:0]  sw_dip_i,
    input logic [AUX_W-1:0]  sw_aux_i,
    input logic [SEG_W-1:0]  seg_val_o,
    input logic [BAR_W-1:0]  bar_o
);
    localparam int CS_W = CS_HI - CS_LO + 1;

    logic hit_c;
    logic wr_pend;
    logic unused_chk;

    assign hit_c      = (addr_i[CS_HI:CS_LO] == CS_MATCH[CS_W-1:0]);
    assign unused_chk = ^{sw_dip_i, sw_aux_i};

    // Note that a decoded write start was seen at the last rising edge.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            wr_pend <= 1'b0;
        end else begin
            wr_pend <= !xfer_start_n_i && hit_c && !rd_wr_i && addr_i[SEL_BIT];
        end
    end

    assert_ack_after_hit_R3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (!xfer_start_n_i && hit_c) |=> !ack_n_o);

    assert_no_ack_on_miss_R1: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !ack_n_o |-> $past(!xfer_start_n_i && hit_c));

    assert_ack_one_edge_R3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !ack_n_o |=> ack_n_o);

    assert_oe_inside_ack_R5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        rdata_oe_o |-> !ack_n_o);

    assert_oe_only_port_read_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        rdata_oe_o |-> $past(rd_wr_i && !addr_i[SEL_BIT]));

    assert_quiet_bus_R5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !rdata_oe_o |-> (rdata_o == '0));

    assert_hold_outputs_R8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !wr_pend |=> $stable({seg_val_o, bar_o}));

    assert_load_value_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        wr_pend |=> (seg_val_o == $past(wdata_i[SEG_W-1:0])));
endmodule

bind swled_bus_slave swled_bus_slave_chk #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .CS_HI   (CS_HI),
    .CS_LO   (CS_LO),
    .CS_MATCH(CS_MATCH),
    .SEL_BIT (SEL_BIT),
    .DIP_W   (DIP_W),
    .AUX_W   (AUX_W),
    .SEG_W   (SEG_W),
    .BAR_W   (BAR_W)
) i_chk (
    .clk_i         (clk_i),
    .rst_n_i       (rst_n_i),
    .xfer_start_n_i(xfer_start_n_i),
    .addr_i        (addr_i),
    .rd_wr_i       (rd_wr_i),
    .wdata_i       (wdata_i),
    .rdata_o       (rdata_o),
    .rdata_oe_o    (rdata_oe_o),
    .ack_n_o       (ack_n_o),
    .sw_dip_i      (sw_dip_i),
    .sw_aux_i      (sw_aux_i),
    .seg_val_o     (seg_val_o),
    .bar_o         (bar_o)
);

// File: tb/test_swled_bus_slave.sv
// Scoreboard bench: the driver pushes expected results, the monitor checks them.
module test_swled_bus_slave;
    localparam int CLK_PERIOD = 40;

    typedef struct {
        logic        exp_ack;
        logic        exp_oe;
        logic [31:0] exp_rdata;
        logic [7:0]  exp_seg;
        logic [7:0]  exp_bar;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_n = 1'b1;
    logic [31:0] addr = '0;
    logic        rw = 1'b1;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        oe;
    logic        ack_n;
    logic [7:0]  dip = '0;
    logic [3:0]  aux = '0;
    logic [7:0]  seg;
    logic [7:0]  bar;

    item_t       sb_q[$];
    logic [7:0]  m_seg = '0;
    logic [7:0]  m_bar = '0;
    int          n_chk = 0;
    int          n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    swled_bus_slave i_swled_bus_slave (
        .clk_i         (clk),
        .rst_n_i       (rst_n),
        .xfer_start_n_i(start_n),
        .addr_i        (addr),
        .rd_wr_i       (rw),
        .wdata_i       (wdata),
        .rdata_o       (rdata),
        .rdata_oe_o    (oe),
        .ack_n_o       (ack_n),
        .sw_dip_i      (dip),
        .sw_aux_i      (aux),
        .seg_val_o     (seg),
        .bar_o         (bar)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Driver: start one access and push what it must produce.
    task automatic xact(input logic [31:0] a, input logic rd, input logic [31:0] wd,
                        input logic [7:0] d, input logic [3:0] x, input string tag);
        item_t it;
        logic  hit;
        hit = (a[25:20] == 6'b101001);
        @(negedge clk);
        dip = d; aux = x; addr = a; rw = rd; wdata = wd; start_n = 1'b0;
        if (hit && !rd && a[2]) begin
            m_seg = wd[7:0];
            m_bar = wd[15:8];
        end
        it.exp_ack   = hit;
        it.exp_oe    = hit && rd && !a[2];
        it.exp_rdata = (hit && rd && !a[2]) ? {20'h0, x, d} : 32'h0;
        it.exp_seg   = m_seg;
        it.exp_bar   = m_bar;
        it.tag       = tag;
        sb_q.push_back(it);
        @(negedge clk);
        start_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    // Monitor: follow each access through its edges and compare.
    initial begin
        forever begin
            item_t it;
            wait (sb_q.size() != 0);
            it = sb_q.pop_front();
            @(posedge clk); #1;
            chk("R3", {it.tag, " ack high at start edge"}, {31'h0, ack_n}, 32'h1);
            @(negedge clk); #1;
            chk("R3", {it.tag, " ack launched on falling edge"}, {31'h0, ack_n}, {31'h0, !it.exp_ack});
            @(posedge clk); #1;
            chk("R1", {it.tag, " ack at sample edge"}, {31'h0, ack_n}, {31'h0, !it.exp_ack});
            chk("R5", {it.tag, " output enable"}, {31'h0, oe}, {31'h0, it.exp_oe});
            chk("R4", {it.tag, " read data"}, rdata, it.exp_rdata);
            chk("R6", {it.tag, " seven-segment value"}, {24'h0, seg}, {24'h0, it.exp_seg});
            chk("R6", {it.tag, " bar pattern"}, {24'h0, bar}, {24'h0, it.exp_bar});
            @(negedge clk); #1;
            chk("R3", {it.tag, " ack released"}, {31'h0, ack_n}, 32'h1);
            chk("R5", {it.tag, " enable released"}, {31'h0, oe}, 32'h0);
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R9", "reset ack", {31'h0, ack_n}, 32'h1);
        chk("R9", "reset enable", {31'h0, oe}, 32'h0);
        chk("R9", "reset data", rdata, 32'h0);
        chk("R9", "reset display", {16'h0, seg, bar}, 32'h0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        xact(32'h0290_0000, 1'b1, 32'h0,         8'hA5, 4'h3, "R4 base read");
        xact(32'h0290_0004, 1'b0, 32'hDEAD_C37E, 8'h00, 4'h0, "R6 base write upper ignored");
        xact(32'h0290_0008, 1'b1, 32'h0,         8'h3C, 4'hC, "R2 shadow read");
        xact(32'h029F_FFF0, 1'b1, 32'h0,         8'hFF, 4'hF, "R10 select 0 shadow read");
        xact(32'h0291_2344, 1'b0, 32'h0000_5A81, 8'h00, 4'h0, "R2 shadow write");
        xact(32'h029A_BCDF, 1'b0, 32'h1234_0F0F, 8'h00, 4'h0, "R10 select 1 shadow write");
        xact(32'h0290_0004, 1'b1, 32'h0,         8'h77, 4'h5, "R7 read output address");
        xact(32'h0290_0000, 1'b0, 32'hFFFF_FFFF, 8'h00, 4'h0, "R8 write input address");
        xact(32'h02A0_0000, 1'b1, 32'h0,         8'h11, 4'h1, "R1 miss read");
        xact(32'h0280_0004, 1'b0, 32'h0000_FFFF, 8'h00, 4'h0, "R1 miss write");
        xact(32'h0390_0004, 1'b0, 32'h0000_AAAA, 8'h00, 4'h0, "R1 miss high field");
        xact(32'h0290_0000, 1'b1, 32'h0,         8'h00, 4'h0, "R4 zero switches");

        wait (sb_q.size() == 0);
        repeat (6) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule